// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block sits on the controller side of an SDRAM pin interface, or inside a memory model, and turns the raw pins into one decoded command per clock. On every rising edge it samples clock enable, the four active-low strobes (chip select, row strobe, column strobe, write enable), the bank-address bits and the address bus. It reports the command as a one-hot strobe, together with its bank, its row or column address and its auto-precharge flag. All outputs are registered and appear one cycle after the edge that sampled the pins.

Alongside the decode it keeps a record for each bank: whether a row is open, and which row. Column commands read this record, so a read or write reports the row it will hit. Commands that break the open/close discipline raise a one-cycle protocol-error flag. An activate issued before the first mode-register load raises the same flag.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A command is taken only when `cke` is 1 and `cs_n` is 0 at the rising edge. Otherwise the cycle counts as a no-operation: `cmd_strobe` is 0 on the next cycle and `bank_open` does not change.
- R2: With `{ras_n,cas_n,we_n}` = 011 activate, 101 read, 100 write, 010 precharge, 001 refresh and 000 mode load raise `cmd_strobe` bit 0, 1, 2, 3, 4 and 5 respectively. The strobe goes high in the cycle after the sampling edge. All other codes raise no bit, and at most one bit is ever high.
- R3: An accepted activate stores `addr[12:0]` as the open row of bank `ba`, sets bit `ba` of `bank_open` and reports that row on `cmd_row`.
- R4: For a read or write, `cmd_col` is `{addr[11], addr[9:0]}` and `cmd_autopre` is `addr[10]`. `cmd_row` carries the open row of the addressed bank, and `addr[12]` does not affect the column.
- R5: An activate that arrives before any mode load sets `proto_err` and leaves the bank closed.
- R6: An activate to a bank that already has an open row sets `proto_err`, and the stored row is kept.
- R7: A read or write to a bank with no open row sets `proto_err`.
- R8: A precharge with `addr[10]`=1 clears every `bank_open` bit. With `addr[10]`=0 it clears only bit `ba`.
- R9: A read or write with `addr[10]`=1 to an open bank clears that bank's `bank_open` bit after the command is reported.
- R10: Synchronous reset clears `bank_open`, the mode-loaded state and every output. An activate issued after reset is therefore an error until a new mode load.
- R11: Banks are tracked independently. Open rows in different banks are retained and reported separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; commands ignored when low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row address, or column bits plus auto-precharge flag |
| cmd_strobe | output | 6 | One-hot decoded command: activate, read, write, precharge, refresh, mode load |
| cmd_bank | output | 2 | Bank of the reported command |
| cmd_row | output | 13 | Row activated, or open row targeted by a column command |
| cmd_col | output | 11 | Column address of a read or write |
| cmd_autopre | output | 1 | Auto-precharge flag of a read or write |
| proto_err | output | 1 | One-cycle pulse for a command that breaks bank or mode-load rules |
| bank_open | output | 4 | Open-row bit per bank |

## Verification
The bound checker watches the command stream on every cycle. It checks that the strobe is never more than one-hot and that a gated cycle yields no strobe. It also checks that an activate to an open bank, or a column command to a closed bank, is flagged on the next cycle, and that a global precharge or an auto-precharged access closes the banks it should. The directed scenarios cover the rest: the row and column mapping, which stored row a later column command reports, the activate-before-mode-load rule, and the loss of the mode-loaded state across reset.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_LMR = 3'd6
  } cmd_e;

  localparam int STROBE_W = 6;

  // strobe bit positions
  localparam int SB_ACT = 0;
  localparam int SB_RD  = 1;
  localparam int SB_WR  = 2;
  localparam int SB_PRE = 3;
  localparam int SB_REF = 4;
  localparam int SB_LMR = 5;

  function automatic logic [STROBE_W-1:0] cmd_to_strobe(input cmd_e c);
    logic [STROBE_W-1:0] s;
    s = '0;
    unique case (c)
      CMD_ACT: s[SB_ACT] = 1'b1;
      CMD_RD:  s[SB_RD]  = 1'b1;
      CMD_WR:  s[SB_WR]  = 1'b1;
      CMD_PRE: s[SB_PRE] = 1'b1;
      CMD_REF: s[SB_REF] = 1'b1;
      CMD_LMR: s[SB_LMR] = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (cke && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_LMR;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdcmd_rule_check.sv
module sdcmd_rule_check
  import sdcmd_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int BANKS = 1 << BANK_W
) (
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              ap_flag,
  input  logic [BANKS-1:0]  open_vec,
  input  logic              mode_loaded,
  output logic              err,
  output logic              act_ok,
  output logic [BANKS-1:0]  close_mask
);

  logic [BANKS-1:0] bank_sel;
  logic             tgt_open;
  logic             is_col;

  always_comb begin
    bank_sel = '0;
    bank_sel[bank] = 1'b1;
  end

  assign tgt_open = open_vec[bank];
  assign is_col   = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    err        = 1'b0;
    act_ok     = 1'b0;
    close_mask = '0;
    if (cmd == CMD_ACT) begin
      if (!mode_loaded || tgt_open) err = 1'b1;
      else                          act_ok = 1'b1;
    end
    if (is_col) begin
      if (!tgt_open)    err = 1'b1;
      else if (ap_flag) close_mask = bank_sel;
    end
    if (cmd == CMD_PRE) begin
      close_mask = ap_flag ? {BANKS{1'b1}} : bank_sel;
    end
  end

endmodule

// File: rtl/sdcmd_bank_tracker.sv
module sdcmd_bank_tracker #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        act_en,
  input  logic [BANK_W-1:0]           act_bank,
  input  logic [ROW_W-1:0]            act_row,
  input  logic [BANKS-1:0]            close_mask,
  output logic [BANKS-1:0]            open_vec,
  output logic [BANKS-1:0][ROW_W-1:0] row_tab
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = act_en && (act_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_vec[b] <= 1'b0;
      end else if (hit) begin
        open_vec[b] <= 1'b1;
      end else if (close_mask[b]) begin
        open_vec[b] <= 1'b0;
      end
    end

    // row storage needs no reset: it is only read while the open bit is set
    always_ff @(posedge clk) begin
      if (hit) row_tab[b] <= act_row;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 11,
  parameter int AP_BIT = 10,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [BANK_W-1:0]   ba,
  input  logic [ADDR_W-1:0]   addr,
  output logic [STROBE_W-1:0] cmd_strobe,
  output logic [BANK_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0]   cmd_row,
  output logic [COL_W-1:0]    cmd_col,
  output logic                cmd_autopre,
  output logic                proto_err,
  output logic [BANKS-1:0]    bank_open
);

  cmd_e                        cmd;
  logic                        err, act_ok, ap_flag, mode_loaded, is_col;
  logic [BANKS-1:0]            close_mask;
  logic [BANKS-1:0][ADDR_W-1:0] row_tab;
  logic [COL_W-1:0]            col_w;

  assign ap_flag = addr[AP_BIT];
  assign is_col  = (cmd == CMD_RD) || (cmd == CMD_WR);

  // column bits skip over the auto-precharge position
  for (genvar i = 0; i < COL_W; i++) begin : g_col
    if (i < AP_BIT) begin : g_lo
      assign col_w[i] = addr[i];
    end else begin : g_hi
      assign col_w[i] = addr[i+1];
    end
  end

  sdcmd_decode u_dec (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdcmd_rule_check #(.BANK_W(BANK_W)) u_rule (
    .cmd         (cmd),
    .bank        (ba),
    .ap_flag     (ap_flag),
    .open_vec    (bank_open),
    .mode_loaded (mode_loaded),
    .err         (err),
    .act_ok      (act_ok),
    .close_mask  (close_mask)
  );

  sdcmd_bank_tracker #(.BANK_W(BANK_W), .ROW_W(ADDR_W)) u_banks (
    .clk        (clk),
    .rst        (rst),
    .act_en     (act_ok),
    .act_bank   (ba),
    .act_row    (addr),
    .close_mask (close_mask),
    .open_vec   (bank_open),
    .row_tab    (row_tab)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_loaded <= 1'b0;
    else if (cmd == CMD_LMR) mode_loaded <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_strobe  <= '0;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_autopre <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      cmd_strobe  <= cmd_to_strobe(cmd);
      proto_err   <= err;
      cmd_bank    <= (cmd == CMD_ACT || is_col || cmd == CMD_PRE) ? ba : '0;
      cmd_col     <= is_col ? col_w : '0;
      cmd_autopre <= is_col && ap_flag;
      if (cmd == CMD_ACT)                  cmd_row <= addr;
      else if (is_col && bank_open[ba])    cmd_row <= row_tab[ba];
      else                                 cmd_row <= '0;
    end
  end

endmodule

// File: rtl/sdcmd_tracker_chk.sv
module sdcmd_tracker_chk #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  localparam int BANKS = 1 << BANK_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ADDR_W-1:0] addr,
  input logic [5:0]        cmd_strobe,
  input logic              proto_err,
  input logic [BANKS-1:0]  bank_open
);

  logic live, pin_act, pin_col, pin_pre;
  assign live    = cke && !cs_n;
  assign pin_act = live && {ras_n, cas_n, we_n} == 3'b011;
  assign pin_col = live && !ras_n == 1'b0 && !cas_n && (ras_n && !cas_n);
  assign pin_pre = live && {ras_n, cas_n, we_n} == 3'b010;

  // R2: never more than one command strobe
  a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_strobe));

  // R1: gated cycle yields no strobe
  a_r1_gated_idle: assert property (@(posedge clk) disable iff (rst)
    !live |=> cmd_strobe == '0);

  // R6: activate to an open bank is flagged
  a_r6_act_open_err: assert property (@(posedge clk) disable iff (rst)
    (pin_act && bank_open[ba]) |=> proto_err);

  // R7: column command to a closed bank is flagged
  a_r7_col_closed_err: assert property (@(posedge clk) disable iff (rst)
    (pin_col && !bank_open[ba]) |=> proto_err);

  // R8: precharge-all closes every bank
  a_r8_pre_all: assert property (@(posedge clk) disable iff (rst)
    (pin_pre && addr[AP_BIT]) |=> bank_open == '0);

  // R9: auto-precharged access closes its bank
  a_r9_autopre_close: assert property (@(posedge clk) disable iff (rst)
    (pin_col && addr[AP_BIT]) |=> !bank_open[$past(ba)]);

endmodule

bind sdram_cmd_tracker sdcmd_tracker_chk #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
  .cmd_strobe(cmd_strobe), .proto_err(proto_err), .bank_open(bank_open)
);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [5:0]  cmd_strobe;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [10:0] cmd_col;
  logic        cmd_autopre, proto_err;
  logic [3:0]  bank_open;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_strobe(cmd_strobe), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_autopre(cmd_autopre), .proto_err(proto_err),
    .bank_open(bank_open)
  );

  always #10 clk = ~clk;

  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         PRE = 3'b010, REF = 3'b001, LMR = 3'b000;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the capturing rising edge
  task automatic send(input logic [2:0] c, input logic [1:0] b,
                      input logic [12:0] a, input logic en = 1'b1,
                      input logic sel_n = 1'b0);
    @(negedge clk);
    cke = en; cs_n = sel_n; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk);
    #1;
    cke = 1'b1; cs_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R10 strobe", cmd_strobe, 0);
    check("R10 open", bank_open, 0);
    check("R10 err", proto_err, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_act_before_mode();
    send(ACT, 2'd1, 13'd5);
    check("R5 err", proto_err, 1);
    check("R5 strobe", cmd_strobe, 6'b000001);
    check("R5 open", bank_open, 0);
  endtask

  task automatic t_mode_and_refresh();
    send(LMR, 2'd0, 13'h033);
    check("R2 lmr strobe", cmd_strobe, 6'b100000);
    check("R2 lmr err", proto_err, 0);
    send(REF, 2'd0, 13'h0);
    check("R2 ref strobe", cmd_strobe, 6'b010000);
  endtask

  task automatic t_activate_two();
    send(ACT, 2'd0, 13'h1ABC);
    check("R3 row", cmd_row, 13'h1ABC);
    check("R3 bank", cmd_bank, 0);
    check("R3 err", proto_err, 0);
    send(ACT, 2'd2, 13'h0123);
    check("R3 open", bank_open, 4'b0101);
    check("R11 row b2", cmd_row, 13'h0123);
  endtask

  task automatic t_column_map();
    send(RD, 2'd0, 13'h0955);
    check("R4 rd strobe", cmd_strobe, 6'b000010);
    check("R4 col", cmd_col, 11'h555);
    check("R4 ap", cmd_autopre, 0);
    check("R11 rd row b0", cmd_row, 13'h1ABC);
    send(WR, 2'd2, 13'h13FF);
    check("R4 wr strobe", cmd_strobe, 6'b000100);
    check("R4 col A12 ignored", cmd_col, 11'h3FF);
    check("R11 wr row b2", cmd_row, 13'h0123);
    check("R4 open kept", bank_open, 4'b0101);
  endtask

  task automatic t_rule_errors();
    send(ACT, 2'd0, 13'h0007);
    check("R6 err", proto_err, 1);
    send(RD, 2'd0, 13'h0001);
    check("R6 row kept", cmd_row, 13'h1ABC);
    check("R6 no err", proto_err, 0);
    send(RD, 2'd3, 13'h0);
    check("R7 rd err", proto_err, 1);
    send(WR, 2'd1, 13'h0);
    check("R7 wr err", proto_err, 1);
    check("R7 open", bank_open, 4'b0101);
  endtask

  task automatic t_gating();
    send(ACT, 2'd3, 13'h0044, 1'b0, 1'b0);
    check("R1 cke strobe", cmd_strobe, 0);
    check("R1 cke open", bank_open, 4'b0101);
    send(ACT, 2'd3, 13'h0044, 1'b1, 1'b1);
    check("R1 cs strobe", cmd_strobe, 0);
    check("R1 cs open", bank_open, 4'b0101);
  endtask

  task automatic t_autopre();
    send(RD, 2'd2, 13'h06AA);
    check("R9 ap", cmd_autopre, 1);
    check("R9 col", cmd_col, 11'h2AA);
    check("R9 open", bank_open, 4'b0001);
  endtask

  task automatic t_precharge();
    send(ACT, 2'd1, 13'h0011);
    send(ACT, 2'd3, 13'h0033);
    check("R11 open", bank_open, 4'b1011);
    send(PRE, 2'd1, 13'h0000);
    check("R8 single", bank_open, 4'b1001);
    check("R8 strobe", cmd_strobe, 6'b001000);
    send(PRE, 2'd0, 13'h0400);
    check("R8 all", bank_open, 4'b0000);
  endtask

  task automatic t_reset_clears_mode();
    do_reset();
    send(ACT, 2'd0, 13'h0002);
    check("R10 mode cleared", proto_err, 1);
    check("R10 open after", bank_open, 0);
  endtask

  initial begin
    do_reset();
    t_act_before_mode();
    t_mode_and_refresh();
    t_activate_two();
    t_column_map();
    t_rule_errors();
    t_gating();
    t_autopre();
    t_precharge();
    t_reset_clears_mode();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule